// File: doc/BRIEF.md
# I2C Register-Write Target Front End

This block is the serial front end of a register-mapped peripheral that sits on a two-wire I2C bus as a target. It brings the bus clock and data lines into the system clock domain, spots START, repeated START and STOP conditions, and compares the 7-bit control address with its own. The upper four bits of that address are fixed and the lower three come from strap inputs, so eight of these targets can share one bus.

After a matching write control byte, the next byte loads the register pointer. Every later byte is a data byte. It is acknowledged, and once its acknowledge clock is over it is handed to the attached register file as a one-cycle write strobe that carries the address and the data. With sequential operation enabled the pointer steps forward after each committed byte and raises an advance pulse. With it disabled the pointer stays put. A byte cut short by STOP or repeated START is dropped. A read control byte turns the block into a simple fetch engine. It requests a byte from the register file at the pointer, shifts that byte out MSB first, and fetches again for as long as the controller acknowledges.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset the data pulldown, the write strobe, the read request and the pointer advance pulse are all low, and the pointer is zero.
- R2: A control byte whose upper seven bits equal {4'b0100, strap} is acknowledged by pulling SDA low in the ninth clock. Any other control byte is not acknowledged, and the block then ignores the bus until the next START.
- R3: After a write control byte, the second byte is acknowledged and loaded into the pointer when its acknowledge clock ends. It produces no write strobe.
- R4: Each data byte that follows is acknowledged, and after its acknowledge clock it gives exactly one single-cycle write strobe whose address is the pointer and whose data is the byte, MSB first on the wire.
- R5: With sequential mode on, every committed data byte raises a one-cycle advance pulse and the pointer increments, wrapping from all ones to zero.
- R6: With sequential mode off, the pointer never changes on data bytes, no advance pulse occurs, and repeated bytes all go to the same address.
- R7: A STOP that arrives part way through a data byte discards that byte: no write strobe.
- R8: A repeated START part way through a byte discards it and begins a new control byte, and the transaction that follows works normally.
- R9: After a read control byte (bit 0 = 1) is acknowledged, the read request is high for one cycle. The read data input is sampled in that cycle and shifted out MSB first, with SDA pulled low only for zero bits.
- R10: When the controller acknowledges a read byte (SDA low in the ninth clock), the pointer advances in sequential mode and another byte is requested. A not-acknowledge ends the read with SDA released.
- R11: The pulldown only changes state while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Low three bits of the device address |
| seq_en | input | 1 | 1: pointer advances after each byte; 0: pointer fixed |
| sda_pull | output | 1 | Open-drain pulldown enable for the data line |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | PTR_W | Register address for the write strobe |
| wr_data | output | 8 | Write data for the strobe |
| ptr_adv | output | 1 | One-cycle pulse when the pointer increments |
| reg_ptr | output | PTR_W | Current register pointer, also the read address |
| rd_req | output | 1 | One-cycle request for the byte at reg_ptr |
| rd_data | input | 8 | Byte from the register file, valid in the rd_req cycle |

## Verification
The bound checker checks, on every cycle, that write strobes, read requests and advance pulses last a single cycle and never coincide in forbidden ways. It also checks that every advance pulse matches a one-step pointer increment, that byte mode never advances, and that the pulldown only moves while SCL is low. What only the bench scenarios can show is the byte-level protocol: which control addresses are acknowledged across every strap setting, that data lands at the right addresses in wrap and byte mode, that bytes cut short by STOP or repeated START vanish, and that read bytes come out with the expected values and order.

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target #(
  parameter int PTR_W = 8,
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] DEV_PREFIX = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] strap,
  input  logic               seq_en,
  output logic               sda_pull,
  output logic               wr_en,
  output logic [PTR_W-1:0]   wr_addr,
  output logic [7:0]         wr_data,
  output logic               ptr_adv,
  output logic [PTR_W-1:0]   reg_ptr,
  output logic               rd_req,
  input  logic [7:0]         rd_data
);

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_REG, S_DATA, S_ACK, S_RD_LOAD, S_TX, S_TX_ACK
  } state_t;

  typedef enum logic [1:0] {K_CW, K_CR, K_REG, K_DAT} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  state_t     st;
  kind_t      kind;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       m_ack;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire scl_r   = scl_s & ~scl_q;
  wire scl_f   = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire [6:0] my_addr = {DEV_PREFIX, strap};
  wire rx_st = (st == S_CTRL) || (st == S_REG) || (st == S_DATA);

  assign rd_req = (st == S_RD_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_CW;
      sh       <= '0;
      cnt      <= '0;
      m_ack    <= 1'b0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ptr_adv  <= 1'b0;
      reg_ptr  <= '0;
    end else begin
      wr_en   <= 1'b0;
      ptr_adv <= 1'b0;
      if (start_c) begin
        st       <= S_CTRL;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        if (rx_st && scl_r && cnt < 4'd8) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        if (rx_st && scl_f && cnt == 4'd8) begin
          cnt <= '0;
          if (st == S_CTRL && sh[7:1] != my_addr) begin
            st <= S_IDLE;
          end else begin
            sda_pull <= 1'b1;
            st       <= S_ACK;
            unique case (st)
              S_CTRL:  kind <= sh[0] ? K_CR : K_CW;
              S_REG:   kind <= K_REG;
              default: kind <= K_DAT;
            endcase
          end
        end
        case (st)
          S_ACK: if (scl_f) begin
            sda_pull <= 1'b0;
            unique case (kind)
              K_CW:  st <= S_REG;
              K_CR:  st <= S_RD_LOAD;
              K_REG: begin
                reg_ptr <= sh[PTR_W-1:0];
                st      <= S_DATA;
              end
              K_DAT: begin
                wr_en   <= 1'b1;
                wr_addr <= reg_ptr;
                wr_data <= sh;
                if (seq_en) begin
                  reg_ptr <= reg_ptr + 1'b1;
                  ptr_adv <= 1'b1;
                end
                st <= S_DATA;
              end
            endcase
          end
          S_RD_LOAD: begin
            sh       <= rd_data;
            sda_pull <= ~rd_data[7];
            cnt      <= '0;
            st       <= S_TX;
          end
          S_TX: if (scl_f) begin
            if (cnt == 4'd7) begin
              sda_pull <= 1'b0;
              st       <= S_TX_ACK;
            end else begin
              sh       <= {sh[6:0], 1'b0};
              sda_pull <= ~sh[6];
              cnt      <= cnt + 4'd1;
            end
          end
          S_TX_ACK: begin
            if (scl_r) m_ack <= ~sda_s;
            if (scl_f) begin
              if (m_ack) begin
                st <= S_RD_LOAD;
                if (seq_en) begin
                  reg_ptr <= reg_ptr + 1'b1;
                  ptr_adv <= 1'b1;
                end
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regwr_target_chk.sv
module i2c_regwr_target_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_in,
  input logic             seq_en,
  input logic             sda_pull,
  input logic             wr_en,
  input logic             rd_req,
  input logic             ptr_adv,
  input logic [PTR_W-1:0] reg_ptr
);

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_wr_rd_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_req));

  assert_adv_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_adv |-> reg_ptr == PTR_W'($past(reg_ptr) + 1'b1));

  assert_byte_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(seq_en) |-> !ptr_adv);

  assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_in);

endmodule

bind i2c_regwr_target i2c_regwr_target_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .seq_en(seq_en),
  .sda_pull(sda_pull), .wr_en(wr_en), .rd_req(rd_req),
  .ptr_adv(ptr_adv), .reg_ptr(reg_ptr)
);

// File: tb/i2c_regwr_target_tb_top.sv
module i2c_regwr_target_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic seq_en = 1'b1;
  logic sda_pull, wr_en, ptr_adv, rd_req;
  logic [7:0] wr_addr, wr_data, reg_ptr, rd_data;
  wire sda_line = sda_m & ~sda_pull;

  assign rd_data = reg_ptr ^ 8'hA5;

  i2c_regwr_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .strap(strap), .seq_en(seq_en), .sda_pull(sda_pull),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_adv(ptr_adv), .reg_ptr(reg_ptr), .rd_req(rd_req), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int wr_cnt = 0, adv_cnt = 0, rdq_cnt = 0, r11_viol = 0;
  logic [7:0] log_a [16];
  logic [7:0] log_d [16];
  logic pull_q = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (wr_en) begin
      if (wr_cnt < 16) begin
        log_a[wr_cnt] <= wr_addr;
        log_d[wr_cnt] <= wr_data;
      end
      wr_cnt <= wr_cnt + 1;
    end
    if (ptr_adv) adv_cnt <= adv_cnt + 1;
    if (rd_req) rdq_cnt <= rdq_cnt + 1;
    if (sda_pull != pull_q && scl_m) r11_viol <= r11_viol + 1;
    pull_q <= sda_pull;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clear_log();
    waitq();
    wr_cnt = 0; adv_cnt = 0; rdq_cnt = 0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq(); scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(); scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq(); waitq();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; waitq(); scl_m = 1'b1; waitq(); waitq(); scl_m = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq();
    ack = ~sda_line;
    waitq(); scl_m = 1'b0; waitq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(); scl_m = 1'b1; waitq(); b[i] = sda_line; waitq(); scl_m = 1'b0;
    end
    send_bit(!mack);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    check(sda_pull == 0, "R1 pulldown", sda_pull, 0);
    check(wr_en == 0 && ptr_adv == 0, "R1 strobes", {wr_en, ptr_adv}, 0);
    check(rd_req == 0, "R1 read request", rd_req, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(reg_ptr == 0, "R1 pointer", reg_ptr, 0);

    // R2: address sweep over all strap settings
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        send_byte({4'b0100, 3'(a), 1'b0}, ack);
        check(ack == (a == s), "R2 address match", ack, a == s);
        bus_stop();
      end
    end
    strap = 3'd5;
    clear_log();
    bus_start();
    send_byte({4'b1100, 3'd5, 1'b0}, ack);
    check(!ack, "R2 foreign prefix", ack, 0);
    send_byte(8'h10, ack);
    check(!ack, "R2 ignored after mismatch", ack, 0);
    send_byte(8'h77, ack);
    bus_stop();
    check(wr_cnt == 0, "R2 no write after mismatch", wr_cnt, 0);

    // R3 R4 R5: sequential writes, including wrap
    seq_en = 1'b1;
    for (int t = 0; t < 3; t++) begin
      logic [7:0] base;
      base = (t == 0) ? 8'hFE : (t == 1) ? 8'h00 : 8'h7F;
      clear_log();
      bus_start();
      send_byte({4'b0100, 3'd5, 1'b0}, ack);
      send_byte(base, ack);
      check(ack, "R3 register byte ack", ack, 1);
      waitq();
      check(reg_ptr == base, "R3 pointer load", reg_ptr, base);
      check(wr_cnt == 0, "R3 no strobe for register byte", wr_cnt, 0);
      for (int i = 0; i < 3; i++) begin
        send_byte(8'(base * 3 + i), ack);
        check(ack, "R4 data ack", ack, 1);
      end
      bus_stop();
      check(wr_cnt == 3, "R4 write count", wr_cnt, 3);
      for (int i = 0; i < 3; i++) begin
        check(log_a[i] == 8'(base + i), "R5 write address", log_a[i], 8'(base + i));
        check(log_d[i] == 8'(base * 3 + i), "R4 write data", log_d[i], 8'(base * 3 + i));
      end
      check(adv_cnt == 3, "R5 advance pulses", adv_cnt, 3);
      check(reg_ptr == 8'(base + 3), "R5 final pointer", reg_ptr, 8'(base + 3));
    end

    // R6: byte mode
    seq_en = 1'b0;
    clear_log();
    bus_start();
    send_byte({4'b0100, 3'd5, 1'b0}, ack);
    send_byte(8'h10, ack);
    for (int i = 0; i < 3; i++) send_byte(8'hC0 + 8'(i), ack);
    bus_stop();
    check(wr_cnt == 3, "R6 write count", wr_cnt, 3);
    for (int i = 0; i < 3; i++) begin
      check(log_a[i] == 8'h10, "R6 fixed address", log_a[i], 8'h10);
      check(log_d[i] == 8'hC0 + 8'(i), "R6 data", log_d[i], 8'hC0 + 8'(i));
    end
    check(adv_cnt == 0, "R6 no advance", adv_cnt, 0);
    check(reg_ptr == 8'h10, "R6 pointer held", reg_ptr, 8'h10);

    // R7: STOP mid byte
    seq_en = 1'b1;
    clear_log();
    bus_start();
    send_byte({4'b0100, 3'd5, 1'b0}, ack);
    send_byte(8'h40, ack);
    send_byte(8'hAA, ack);
    send_bits(8'h3C, 4);
    bus_stop();
    check(wr_cnt == 1, "R7 partial byte dropped", wr_cnt, 1);
    check(reg_ptr == 8'h41, "R7 pointer", reg_ptr, 8'h41);

    // R8: repeated START mid byte
    clear_log();
    bus_start();
    send_byte({4'b0100, 3'd5, 1'b0}, ack);
    send_byte(8'h50, ack);
    send_bits(8'hF0, 5);
    bus_start();
    send_byte({4'b0100, 3'd5, 1'b0}, ack);
    check(ack, "R8 control after restart", ack, 1);
    send_byte(8'h60, ack);
    send_byte(8'h5A, ack);
    bus_stop();
    check(wr_cnt == 1, "R8 write count", wr_cnt, 1);
    check(log_a[0] == 8'h60 && log_d[0] == 8'h5A, "R8 write after restart",
          {log_a[0], log_d[0]}, 16'h605A);

    // R9 R10: sequential read
    clear_log();
    bus_start();
    send_byte({4'b0100, 3'd5, 1'b0}, ack);
    send_byte(8'h20, ack);
    bus_start();
    send_byte({4'b0100, 3'd5, 1'b1}, ack);
    check(ack, "R9 read control ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      read_byte(i < 2, b);
      check(b == (8'(8'h20 + i) ^ 8'hA5), "R9 read data", b, 8'(8'h20 + i) ^ 8'hA5);
    end
    check(sda_pull == 0, "R10 released after NACK", sda_pull, 0);
    bus_stop();
    check(rdq_cnt == 3, "R10 request count", rdq_cnt, 3);
    check(reg_ptr == 8'h22, "R10 pointer", reg_ptr, 8'h22);
    check(wr_cnt == 0, "R9 no write during read", wr_cnt, 0);

    // R10: byte-mode read
    seq_en = 1'b0;
    clear_log();
    bus_start();
    send_byte({4'b0100, 3'd5, 1'b0}, ack);
    send_byte(8'h30, ack);
    bus_start();
    send_byte({4'b0100, 3'd5, 1'b1}, ack);
    for (int i = 0; i < 2; i++) begin
      read_byte(i < 1, b);
      check(b == (8'h30 ^ 8'hA5), "R10 byte-mode read", b, 8'h30 ^ 8'hA5);
    end
    bus_stop();
    check(adv_cnt == 0 && reg_ptr == 8'h30, "R10 byte-mode pointer", reg_ptr, 8'h30);

    check(r11_viol == 0, "R11 pulldown moves only with SCL low", r11_viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule